// File: doc/BRIEF.md
# Timestamped Circular Pipeline Readout

The block is the front-end pipeline of a triggered readout channel. On every clock it stores one input sample into a circular memory of 2^AW entries. It also keeps a timestamp counter that restarts at zero at the start of each burst. Writing never pauses, so the channel has no dead time. With AW = 13 and a 40 MHz sample clock the ring holds 204.8 µs of history. The default parameter is smaller so that the elaborated memory stays compact.

A trigger carries a type code and the timestamp of the time window of interest. Triggers wait in a small in-order queue. When a trigger reaches the head of the queue, the block compares its timestamp with the running count. A trigger that is too old, or one that lies in the future, is dropped and raises a sticky error flag. Any other trigger produces a frame. The frame has one header word followed by a run-time-selected number of consecutive samples, read out while new samples keep arriving. A trigger offered while the queue is full is discarded silently, because upstream rate control is expected to prevent that case.

Top module: `ring_readout`

## Requirements
- R1: The sample presented in a cycle with `burst_start` high gets timestamp 0. Each later cycle's sample gets the previous timestamp plus one.
- R2: The sample with timestamp t is stored at ring address t mod 2^AW, and storing continues every cycle, including during readouts. A readout whose window crosses ring address 2^AW-1 continues at address 0.
- R3: Every frame begins with a header word whose upper TYPE_W bits are the trigger type and whose lower TS_W bits are the trigger timestamp. At least one idle cycle separates consecutive frames.
- R4: After the header, the frame carries `rd_len` samples with timestamps ts, ts+1, … in order. The samples appear on consecutive cycles with no gap, and each is zero-extended into `out_data`.
- R5: `out_last` is high only on the final word of a frame. When `rd_len` is 0, the frame is the header alone with `out_last` high.
- R6: When a queued trigger starts, its age is (current timestamp − trigger timestamp) mod 2^TS_W. An age of 2^AW or more produces no frame and sets `stale_err`. An age from 0 to 2^AW−1 is served, including samples still being written during the readout.
- R7: `stale_err` stays high until a cycle with `burst_start` high clears it.
- R8: Up to 2^QAW triggers are queued and served in arrival order. A trigger offered while the queue is full is dropped.
- R9: After reset, `out_valid`, `out_last` and `stale_err` are low.
- R10: `rd_len` is sampled when a trigger's readout starts, so different triggers can use different lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Restarts the timestamp at the current sample |
| smp_in | input | DATA_W | Sample written into the ring this cycle |
| trig_valid | input | 1 | Trigger word present this cycle |
| trig_type | input | TYPE_W | Trigger type code |
| trig_ts | input | TS_W | Timestamp of the first wanted sample |
| rd_len | input | LEN_W | Number of samples per frame |
| out_valid | output | 1 | Frame word valid |
| out_last | output | 1 | Final word of the frame |
| out_data | output | TYPE_W+TS_W | Header or zero-extended sample |
| stale_err | output | 1 | Sticky flag for a skipped trigger |

## Verification
Each sample value is a hash of its own timestamp. Any slip of one in the counter, the write address or the read address therefore shows up as a wrong value, and stale data from the previous lap of the ring does not match. The tests use several stimulus patterns:
- Single triggers with lengths 0, 1, 4 and 8, which separate header-only framing from sample framing.
- A window that straddles the ring wrap.
- A window that starts at the current sample, which separates a correct same-cycle write/read ordering from a wrong one.
- Six back-to-back triggers, which test queue order and the drop of the trigger that meets a full queue.
- Ages of exactly 2^AW−1 and 2^AW, and an age far beyond the ring, which locate the stale threshold to within one count.

// File: rtl/ring_readout.sv
module ring_readout #(
  parameter int DATA_W = 16,
  parameter int TYPE_W = 4,
  parameter int TS_W   = 20,
  parameter int AW     = 10,
  parameter int LEN_W  = 8,
  parameter int QAW    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     burst_start,
  input  logic [DATA_W-1:0]        smp_in,
  input  logic                     trig_valid,
  input  logic [TYPE_W-1:0]        trig_type,
  input  logic [TS_W-1:0]          trig_ts,
  input  logic [LEN_W-1:0]         rd_len,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [TYPE_W+TS_W-1:0]   out_data,
  output logic                     stale_err
);
  localparam int DEPTH = 1 << AW;
  localparam int QD    = 1 << QAW;
  localparam int OUT_W = TYPE_W + TS_W;

  typedef enum logic [1:0] {IDLE, HDR, DATA} st_t;

  st_t               state;
  logic [TS_W-1:0]   now, cur_ts, age;
  logic [DATA_W-1:0] ring [DEPTH];
  logic [DATA_W-1:0] rdata;
  logic [AW-1:0]     ptr;
  logic [LEN_W-1:0]  left;
  logic [OUT_W-1:0]  hdr;
  logic [OUT_W-1:0]  q [QD];
  logic [QAW:0]      wp, rp;
  logic              full, empty, push, pop, stale;
  logic [OUT_W-1:0]  head;

  assign cur_ts = burst_start ? '0 : now;
  assign full   = (wp[QAW] != rp[QAW]) && (wp[QAW-1:0] == rp[QAW-1:0]);
  assign empty  = (wp == rp);
  assign push   = trig_valid && !full;
  assign pop    = (state == IDLE) && !empty;
  assign head   = q[rp[QAW-1:0]];
  assign age    = cur_ts - head[TS_W-1:0];
  assign stale  = |age[TS_W-1:AW];

  always_ff @(posedge clk) begin
    ring[cur_ts[AW-1:0]] <= smp_in;
    rdata <= ring[ptr];
    if (push) q[wp[QAW-1:0]] <= {trig_type, trig_ts};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now       <= '0;
      state     <= IDLE;
      wp        <= '0;
      rp        <= '0;
      stale_err <= 1'b0;
      ptr       <= '0;
      left      <= '0;
      hdr       <= '0;
    end else begin
      now <= cur_ts + 1'b1;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (pop && stale)     stale_err <= 1'b1;
      else if (burst_start) stale_err <= 1'b0;
      case (state)
        IDLE: if (pop && !stale) begin
          hdr   <= head;
          ptr   <= head[AW-1:0];
          left  <= rd_len;
          state <= HDR;
        end
        HDR: begin
          ptr   <= ptr + 1'b1;
          state <= (left == '0) ? IDLE : DATA;
        end
        DATA: begin
          ptr  <= ptr + 1'b1;
          left <= left - 1'b1;
          if (left == LEN_W'(1)) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign out_valid = (state != IDLE);
  assign out_last  = (state == HDR && left == '0) || (state == DATA && left == LEN_W'(1));
  assign out_data  = (state == HDR) ? hdr : OUT_W'(rdata);

  assert_ts_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> now == TS_W'(1));
  assert_gap_between_frames_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  assert_no_gap_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  assert_last_inside_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_stale_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && stale) |=> (stale_err && !out_valid));
  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_err && !burst_start) |=> stale_err);
  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && !(pop && stale)) |=> !stale_err);
  assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp - rp) <= (QAW+1)'(QD));
endmodule

// File: tb/sim_ring_readout.sv
module sim_ring_readout;
  localparam int DATA_W = 16, TYPE_W = 4, TS_W = 20, AW = 10, LEN_W = 8, QAW = 2;
  localparam int OUT_W = TYPE_W + TS_W;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, burst_start = 0, trig_valid = 0;
  logic [DATA_W-1:0] smp_in = '0;
  logic [TYPE_W-1:0] trig_type = '0;
  logic [TS_W-1:0]   trig_ts = '0;
  logic [LEN_W-1:0]  rd_len = '0;
  logic out_valid, out_last, stale_err;
  logic [OUT_W-1:0] out_data;

  int checks = 0, errors = 0, words = 0;
  logic [TS_W-1:0] bts = '0;
  logic bs_req = 0;
  logic [OUT_W:0] exp_q[$];
  string tag_q[$];

  ring_readout #(.DATA_W(DATA_W), .TYPE_W(TYPE_W), .TS_W(TS_W), .AW(AW),
                 .LEN_W(LEN_W), .QAW(QAW)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .smp_in(smp_in),
    .trig_valid(trig_valid), .trig_type(trig_type), .trig_ts(trig_ts),
    .rd_len(rd_len), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data), .stale_err(stale_err));

  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(input logic [TS_W-1:0] t);
    return (t[15:0] * 16'd40503) ^ {t[19:16], 12'h5A3};
  endfunction

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
    end
  endtask

  // driver of the sample stream: bts is the timestamp of the sample now driven
  initial forever begin
    @(negedge clk);
    if (bs_req) begin bts = '0; bs_req = 0; burst_start = 1; end
    else begin bts = bts + 1'b1; burst_start = 0; end
    smp_in = pat(bts);
  end

  task automatic expect_frame(input logic [TYPE_W-1:0] ty, input logic [TS_W-1:0] ts,
                              input int len, input string tag);
    exp_q.push_back({(len == 0), ty, ts}); tag_q.push_back({tag, " header R3"});
    for (int k = 0; k < len; k++) begin
      exp_q.push_back({(k == len-1), OUT_W'(pat(ts + TS_W'(k)))});
      tag_q.push_back({tag, " sample R4"});
    end
  endtask

  // trigger offered in the current cycle; timestamp relative to the driven sample
  task automatic trig(input logic [TYPE_W-1:0] ty, input logic [TS_W-1:0] ts);
    trig_valid = 1; trig_type = ty; trig_ts = ts;
    @(negedge clk); #1; trig_valid = 0;
  endtask

  task automatic sync(); @(negedge clk); #1; endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
  endtask

  // monitor: compares each produced word against the scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid) begin
      words++;
      if (exp_q.size() == 0)
        check(0, "unexpected word R6/R8", int'(out_data), 0);
      else begin
        logic [OUT_W:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(out_data == e[OUT_W-1:0], t, int'(out_data), int'(e[OUT_W-1:0]));
        check(out_last == e[OUT_W], {t, " last flag R5"}, int'(out_last), int'(e[OUT_W]));
      end
    end
  end

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    repeat (5) @(negedge clk);
    #1;
    check(out_valid == 0, "reset out_valid R9", int'(out_valid), 0);
    check(out_last == 0, "reset out_last R9", int'(out_last), 0);
    check(stale_err == 0, "reset stale_err R9", int'(stale_err), 0);
    rst_n = 1;
    bs_req = 1;
    repeat (30) sync();

    // R1: timestamps restart at the burst
    rd_len = 4;
    expect_frame(4'h1, 20'd2, 4, "R1 early burst");
    trig(4'h1, 20'd2);
    drain();
    repeat (1100) sync();

    // R4 / R10: lengths chosen per trigger
    expect_frame(4'h3, bts - 20, 4, "R10 len4");
    trig(4'h3, bts - 20);
    drain();
    rd_len = 0;
    expect_frame(4'h5, bts - 10, 0, "R5 header only");
    trig(4'h5, bts - 10);
    drain();
    rd_len = 1;
    expect_frame(4'h6, bts - 7, 1, "R10 len1");
    trig(4'h6, bts - 7);
    drain();

    // R2: window across the ring wrap
    rd_len = 8;
    while (bts[AW-1:0] != 20) sync();
    expect_frame(4'h7, bts - 23, 8, "R2 wrap");
    trig(4'h7, bts - 23);
    drain();

    // R6: age zero, samples written during readout
    rd_len = 3;
    expect_frame(4'h8, bts + 1, 3, "R6 age zero");
    trig(4'h8, bts + 1);
    drain();

    // R8: six back-to-back triggers, the sixth meets a full queue
    rd_len = 8;
    w0 = words;
    for (int i = 0; i < 6; i++) begin
      if (i < 5) expect_frame(TYPE_W'(i + 9), bts - 40 - TS_W'(i * 3), 8, "R8 order");
      trig(TYPE_W'(i + 9), bts - 40 - TS_W'(i * 3));
    end
    drain();
    repeat (20) sync();
    check(words - w0 == 45, "R8 words after full queue", words - w0, 45);

    // R6: far stale trigger
    check(stale_err == 0, "R6 flag before stale", int'(stale_err), 0);
    w0 = words;
    trig(4'h2, bts - 1500);
    repeat (6) sync();
    check(stale_err == 1, "R6 flag after stale", int'(stale_err), 1);
    check(words == w0, "R6 no frame for stale", words - w0, 0);
    repeat (10) sync();
    check(stale_err == 1, "R7 flag sticky", int'(stale_err), 1);

    // R7: burst start clears; R1 restart
    bs_req = 1;
    repeat (3) sync();
    check(stale_err == 0, "R7 flag cleared", int'(stale_err), 0);
    repeat (1100) sync();

    // R6: boundary ages 2^AW-1 (served) and 2^AW (skipped)
    rd_len = 2;
    expect_frame(4'hC, bts + 2 - TS_W'(DEPTH), 2, "R6 age max");
    trig(4'hC, bts + 2 - TS_W'(DEPTH));
    drain();
    check(stale_err == 0, "R6 flag at age max", int'(stale_err), 0);
    w0 = words;
    trig(4'hD, bts + 1 - TS_W'(DEPTH));
    repeat (6) sync();
    check(stale_err == 1, "R6 flag at age depth", int'(stale_err), 1);
    check(words == w0, "R6 no frame at age depth", words - w0, 0);
    check(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule